// File: doc/BRIEF.md
# Signed Radix-4 Multiplier with Generated Sign Bits

This block multiplies two N-bit two's-complement operands into a 2N-bit signed product (N = 16 by default). The multiplier operand is scanned in overlapping bit pairs, giving N/2 digits from the set {-2, -1, 0, +1, +2}. Each digit steers a selector that forms one row of N+1 bits from the multiplicand. A row that needs negation is inverted, and its "+1" is injected at the row's lowest bit.

Each row's top bit is inverted instead of being sign-extended. A one is placed just above that bit, and a single further one is placed at weight 2^N. Because of this, every row stays N+1 bits wide and no sign has to travel from row to row. The rows are compressed in a carry-save chain of 3:2 adders. A final carry-propagate add resolves the result, and anything above bit 2N-1 is dropped.

Operands are captured in an input register when `in_valid` is high. The combinational core then feeds an output register, so a result leaves two clock edges after its operands were taken. A new pair can be accepted on every cycle.

Top module: `booth_sg_mult`

## Requirements
- R1: `product` equals the signed product of `a` and `b` as a 2N-bit two's-complement value, for any pair of operands.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high after the second rising edge that follows it, carrying that pair's product. Pairs offered on consecutive cycles come out on consecutive cycles, in order.
- R3: While `rst_n` is low and after its release, `out_valid` is 0 and `product` is 0 until the first result emerges.
- R4: In cycles where `out_valid` is 0, `product` keeps the last result. Operands presented with `in_valid` low have no effect on either output.
- R5: The most negative operand times itself gives +2^(2N-2) (0x40000000 for N = 16). The carry out of bit 2N-1 is discarded.
- R6: A zero operand on either side gives 0. An operand of -1 (all ones) gives the two's-complement negation of the other operand.
- R7: The largest positive operand times itself, and times the most negative operand, give the exact signed results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `a` and `b` are taken at this edge |
| a | input | N | Multiplicand, two's complement |
| b | input | N | Multiplier (recoded operand), two's complement |
| out_valid | output | 1 | `product` holds a new result this cycle |
| product | output | 2N | Signed product, two's complement |

## Verification
In a single cycle, the block can be capturing a new operand pair while it also updates the output register with the product of an earlier pair. Streams of pairs sent on back-to-back cycles force this overlap. These streams alternate with streams broken by idle cycles, and during those idle cycles the operand inputs carry junk values.

A queue holds the expected products in order. A cycle-by-cycle model of the two-edge delay judges when `out_valid` must rise. Any result that is lost, duplicated or shifted by one slot shows up as a mismatch against the head of the queue.

// File: rtl/booth_sg_mult.sv
module booth_sg_mult #(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           out_valid,
  output logic [2*N-1:0] product
);
  localparam int NR = N / 2;
  localparam int W  = 2 * N;

  logic [N-1:0] a_q, b_q;
  logic         v_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        a_q <= a;
        b_q <= b;
      end
    end

  wire [N+1:0] ae = {a_q[N-1], a_q, 1'b0};
  wire [N:0]   bx = {b_q, 1'b0};

  logic [W-1:0] rows [NR];
  logic [NR-1:0] negs;

  for (genvar j = 0; j < NR; j++) begin : g_row
    wire [2:0] t   = bx[2*j+2 -: 3];
    wire       neg = t[2] & ~(t[1] & t[0]);
    wire       one = t[1] ^ t[0];
    wire       two = (t[2] & ~t[1] & ~t[0]) | (~t[2] & t[1] & t[0]);
    logic [N:0] pp;
    for (genvar i = 0; i <= N; i++) begin : g_bit
      assign pp[i] = ((one & ae[i+1]) | (two & ae[i])) ^ neg;
    end
    assign negs[j] = neg;
    assign rows[j] = {{(N-1){1'b0}}, ~pp[N], pp[N-1:0]} << (2*j);
  end

  logic [W-1:0] fixv, s_v, c_v, t_v, core;

  always_comb begin
    fixv = '0;
    fixv[N] = 1'b1;
    for (int j = 0; j < NR; j++) begin
      fixv[2*j]       = negs[j];
      fixv[N + 2*j + 1] = 1'b1;
    end
    s_v = rows[0];
    c_v = fixv;
    for (int j = 1; j < NR; j++) begin
      t_v = s_v ^ c_v ^ rows[j];
      c_v = ((s_v & c_v) | (s_v & rows[j]) | (c_v & rows[j])) << 1;
      s_v = t_v;
    end
    core = s_v + c_v;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= v_q;
      if (v_q) product <= core;
    end

  wire signed [W-1:0] ref_mul = $signed(a_q) * $signed(b_q);

  // R1
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |=> product == $past(ref_mul));
  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  // R3
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
  // R4
  hold_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_q |=> $stable(product));
endmodule

// File: tb/test_booth_sg_mult.sv
module test_booth_sg_mult;
  localparam int N = 16;
  localparam int W = 2 * N;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [N-1:0] a = '0, b = '0;
  logic out_valid;
  logic [W-1:0] product;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] last_p = '0;
  bit           have_last = 0;
  logic         vd1 = 0, vd2 = 0;

  always #4 clk = ~clk;

  booth_sg_mult #(.N(N)) i_booth_sg_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .product(product)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin vd1 <= 0; vd2 <= 0; end
    else begin vd1 <= in_valid; vd2 <= vd1; end

  task automatic drive(input logic [N-1:0] x, input logic [N-1:0] y, input string tag);
    logic signed [W-1:0] e;
    @(negedge clk);
    a = x; b = y; in_valid = 1;
    e = $signed(x) * $signed(y);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0;
      a = N'($urandom); b = N'($urandom);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (out_valid !== vd2) begin
      errors++;
      $display("FAIL R2 out_valid actual %b expected %b", out_valid, vd2);
    end
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 result with empty queue actual %h expected none", product);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (product !== e) begin
          errors++;
          $display("FAIL %s product actual %h expected %h", t, product, e);
        end
      end
      last_p = product; have_last = 1;
    end else begin
      checks++;
      if (product !== (have_last ? last_p : '0)) begin
        errors++;
        $display("FAIL R4 held product actual %h expected %h", product, have_last ? last_p : '0);
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [N-1:0] MINN = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MAXP = {1'b0, {(N-1){1'b1}}};

  initial begin
    repeat (2) @(negedge clk);
    // R3 during reset
    checks++;
    if (out_valid !== 1'b0 || product !== '0) begin
      errors++;
      $display("FAIL R3 reset outputs actual %b/%h expected 0/0", out_valid, product);
    end
    @(negedge clk); rst_n = 1;
    idle(3);
    drive(MINN, MINN, "R5");
    idle(1);
    checks++;
    if ($signed(MINN) * $signed(MINN) !== 32'sh40000000) begin
      errors++;
      $display("FAIL R5 model actual %h expected 40000000", $signed(MINN) * $signed(MINN));
    end
    drive('0, 16'h1234, "R6");
    drive(16'hBEEF, '0, "R6");
    drive('1, 16'h7A5C, "R6");
    drive(16'h8001, '1, "R6");
    drive('1, '1, "R6");
    drive('1, MINN, "R6");
    idle(2);
    drive(MAXP, MAXP, "R7");
    drive(MAXP, MINN, "R7");
    drive(MINN, MAXP, "R7");
    idle(4);
    // R1 random, back-to-back and gapped (R2)
    for (int k = 0; k < 300; k++) begin
      drive(N'($urandom), N'($urandom), "R1");
      if (k % 7 == 3) idle(1 + (k % 3));
    end
    idle(5);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 results missing actual %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule